// File: doc/BRIEF.md
# Equipment-Control Command Mailbox Writer

This block delivers a command to a processor that polls a mailbox of 16-bit words. The receiver treats the command as complete only when the opcode word at index 0 has been written. So the block writes the words in a fixed reverse order: first the payload words from index 2 upward, then the length word at index 1, and the opcode word last. Each word goes to byte offset twice its index. After every accepted write the block waits a fixed settle interval before it does anything else. In the target system that interval is 5 ms, and here it is a cycle-count parameter.

The block builds two kinds of frame from a short request. A tone frame switches a continuous control tone on or off and has two words. A message frame carries up to ten message bytes and a burst selector, and always has eighteen words. A one-cycle start pulse latches the request and the block drives the write port. `busy` stays high while the command is in flight, and `done` pulses once when the settle interval after the opcode write has passed.

Top module: `mbx_cmd_writer`

## Requirements
- R1: After a synchronous active-low reset, `wr_en`, `busy` and `done` are all low.
- R2: The words are written in this order: indices 2 up to frame length minus 1 in ascending order, then index 1, then index 0 (the opcode) last. Each word goes to `wr_addr` = 2 × index.
- R3: When `wr_en` is high and `wr_ready` is low, `wr_en`, `wr_addr` and `wr_data` hold their values into the next cycle. A write completes in a cycle where both are high.
- R4: After each completed write, `wr_en` stays low for exactly `SETTLE_CYCLES` cycles before the next word is offered.
- R5: `busy` is high from the cycle after an accepted start until the command ends. `done` is high for exactly one cycle, `SETTLE_CYCLES`+1 cycles after the opcode write completes, and `busy` is low in that cycle.
- R6: In a message frame (`cmd_tone`=0), word 0 is {CMD_TYPE, SEND_CODE}, which is 16'h0208 by default. Word 1 is the clipped length plus 2. Word 2 is the clipped length.
- R7: In a message frame, word 3 encodes `burst_sel`. 2'b10 (data burst) gives 16'h0001, 2'b01 (tone burst) gives 16'h0000, and 2'b00 or 2'b11 (no burst) gives 16'hFFFF.
- R8: A message frame is always 18 words. `msg_len` is clipped to 10. Byte k of `msg_bytes` (bits 8k+7:8k) is zero-extended into word 4+k for each k below the clipped length. All other words up to index 17 are zero.
- R9: A tone frame (`cmd_tone`=1) has two words. Word 0 is {CMD_TYPE, TONE_ON_CODE}, default 16'h0203, when `tone_on`=1, and {CMD_TYPE, TONE_OFF_CODE}, default 16'h0204, when `tone_on`=0. Word 1 is zero.
- R10: A start pulse while `busy` is high is ignored. Request inputs are latched at the accepted start, and later changes to them do not alter the frame being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send a command |
| cmd_tone | input | 1 | 1: tone frame, 0: message frame |
| tone_on | input | 1 | Tone state for a tone frame |
| msg_len | input | 4 | Message byte count (clipped to 10) |
| burst_sel | input | 2 | Burst selector for a message frame |
| msg_bytes | input | 80 | Message bytes, byte k at bits 8k+7:8k |
| wr_addr | output | 6 | Mailbox byte offset of the current word |
| wr_data | output | 16 | Word being written |
| wr_en | output | 1 | Write strobe, held until accepted |
| wr_ready | input | 1 | Mailbox accepts the write this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets these corner cases:
- The opcode must arrive last. A design that wrote index 0 first, or wrote index 1 before the payload, would let the receiver act on a half-written frame. The bench catches this through the logged address order.
- Lengths above ten must be clipped in both length words and in the byte copy. A design without the clip would report length 17 and leak stray bytes past word 13.
- Each burst code is checked, including the reserved selector, which must read as no burst.
- A stalled port must hold the word and delay the settle count. A design that started counting at the strobe, not at acceptance, would shorten the gap between writes.
- A second start mid-command, with changed inputs, must not restart the sequence or corrupt the frame.
- The `done` pulse must be single and timed after the last settle interval.

// File: rtl/mbx_pkg.sv
// Package: shared frame layout constants and types for the mailbox writer.
// Assumes a fixed 18-word message frame and a 10-byte message limit.
package mbx_pkg;
    localparam int FRAME_WORDS = 18;
    localparam int TONE_WORDS  = 2;
    localparam int MSG_MAX     = 10;
    localparam int LEN_W       = 4;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int FL_W        = $clog2(FRAME_WORDS + 1);
    localparam int ADDR_W      = IDX_W + 1;
    localparam int WORD_W      = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_SETTLE = 2'd2
    } mbx_state_e;

    typedef enum logic [1:0] {
        BURST_NONE = 2'b00,
        BURST_TONE = 2'b01,
        BURST_DATA = 2'b10,
        BURST_RSV  = 2'b11
    } burst_e;

    // Number of words in a frame of the given kind.
    function automatic logic [FL_W-1:0] frame_len_of(input logic is_tone);
        return is_tone ? FL_W'(TONE_WORDS) : FL_W'(FRAME_WORDS);
    endfunction
endpackage

// File: rtl/mbx_frame_build.sv
// Frame builder: returns the word at a given index of the latched command.
// Purely combinational; assumes the request fields stay stable while used.
module mbx_frame_build
    import mbx_pkg::*;
#(
    parameter logic [7:0] CMD_TYPE      = 8'h02,
    parameter logic [7:0] SEND_CODE     = 8'h08,
    parameter logic [7:0] TONE_ON_CODE  = 8'h03,
    parameter logic [7:0] TONE_OFF_CODE = 8'h04
) (
    input  logic                  is_tone,
    input  logic                  tone_on,
    input  logic [LEN_W-1:0]      len_raw,
    input  logic [1:0]            burst,
    input  logic [8*MSG_MAX-1:0]  msg,
    input  logic [IDX_W-1:0]      idx,
    output logic [WORD_W-1:0]     word,
    output logic [FL_W-1:0]       frame_len
);
    logic [LEN_W-1:0]  len_c;
    logic [WORD_W-1:0] burst_word;
    logic [WORD_W-1:0] msg_word;
    burst_e            burst_k;

    // Clip the message length to the frame capacity.
    always_comb begin
        len_c = (len_raw > LEN_W'(MSG_MAX)) ? LEN_W'(MSG_MAX) : len_raw;
    end

    // Encode the burst selector into its frame word.
    always_comb begin
        burst_k = burst_e'(burst);
        case (burst_k)
            BURST_DATA: burst_word = 16'h0001;
            BURST_TONE: burst_word = 16'h0000;
            default:    burst_word = 16'hFFFF;
        endcase
    end

    // Pick the zero-extended message byte for payload indices.
    always_comb begin
        msg_word = '0;
        for (int k = 0; k < MSG_MAX; k++) begin
            if (idx == IDX_W'(k + 4) && LEN_W'(k) < len_c)
                msg_word = {8'h00, msg[8*k +: 8]};
        end
    end

    // Select the word of the frame for the requested index.
    always_comb begin
        frame_len = frame_len_of(is_tone);
        if (is_tone) begin
            if (idx == '0)
                word = {CMD_TYPE, tone_on ? TONE_ON_CODE : TONE_OFF_CODE};
            else
                word = '0;
        end else begin
            case (idx)
                IDX_W'(0): word = {CMD_TYPE, SEND_CODE};
                IDX_W'(1): word = WORD_W'(len_c) + 16'd2;
                IDX_W'(2): word = WORD_W'(len_c);
                IDX_W'(3): word = burst_word;
                default:   word = msg_word;
            endcase
        end
    end
endmodule

// File: rtl/mbx_order_seq.sv
// Order sequencer: gives the first index of a frame and the index after a
// given one (payload ascending, then index 1, then opcode index 0).
// Assumes frame_len is at least 2.
module mbx_order_seq
    import mbx_pkg::*;
(
    input  logic [FL_W-1:0]  frame_len,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] next_idx,
    output logic             is_last
);
    logic [FL_W:0] idx_inc;

    // First word written is index 2 when a payload exists, else index 1.
    always_comb begin
        first_idx = (frame_len > FL_W'(2)) ? IDX_W'(2) : IDX_W'(1);
    end

    // Step to the following index in reverse-priority order.
    always_comb begin
        idx_inc = (FL_W+1)'(idx) + 1'b1;
        is_last = (idx == '0);
        if (idx >= IDX_W'(2))
            next_idx = (idx_inc < (FL_W+1)'(frame_len)) ? IDX_W'(idx_inc) : IDX_W'(1);
        else
            next_idx = '0;
    end
endmodule

// File: rtl/mbx_settle_timer.sv
// Settle timer: after a load pulse, raises expire in the last of
// SETTLE_CYCLES cycles. Assumes SETTLE_CYCLES >= 1.
module mbx_settle_timer #(
    parameter int SETTLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Count the settle interval down from the load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= CW'(SETTLE_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/mbx_cmd_writer.sv
// Command mailbox writer top: latches a request on start, walks the frame in
// reverse-priority order through the write port, and waits a settle
// interval after each accepted word. Assumes a single mailbox client.
module mbx_cmd_writer
    import mbx_pkg::*;
#(
    parameter int         SETTLE_CYCLES = 1_000_000,
    parameter logic [7:0] CMD_TYPE      = 8'h02,
    parameter logic [7:0] SEND_CODE     = 8'h08,
    parameter logic [7:0] TONE_ON_CODE  = 8'h03,
    parameter logic [7:0] TONE_OFF_CODE = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cmd_tone,
    input  logic                 tone_on,
    input  logic [LEN_W-1:0]     msg_len,
    input  logic [1:0]           burst_sel,
    input  logic [8*MSG_MAX-1:0] msg_bytes,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_W-1:0]    wr_data,
    output logic                 wr_en,
    input  logic                 wr_ready,
    output logic                 busy,
    output logic                 done
);
    mbx_state_e           state_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 tone_q;
    logic                 on_q;
    logic [LEN_W-1:0]     len_q;
    logic [1:0]           burst_q;
    logic [8*MSG_MAX-1:0] msg_q;
    logic                 done_q;

    logic [WORD_W-1:0]    word;
    logic [FL_W-1:0]      flen_latched;
    logic [FL_W-1:0]      flen_sel;
    logic [IDX_W-1:0]     first_idx;
    logic [IDX_W-1:0]     next_idx;
    logic                 is_last;
    logic                 accept;
    logic                 expire;

    mbx_frame_build #(
        .CMD_TYPE      (CMD_TYPE),
        .SEND_CODE     (SEND_CODE),
        .TONE_ON_CODE  (TONE_ON_CODE),
        .TONE_OFF_CODE (TONE_OFF_CODE)
    ) u_build (
        .is_tone   (tone_q),
        .tone_on   (on_q),
        .len_raw   (len_q),
        .burst     (burst_q),
        .msg       (msg_q),
        .idx       (idx_q),
        .word      (word),
        .frame_len (flen_latched)
    );

    // Idle uses the live request kind to find the first index.
    assign flen_sel = (state_q == ST_IDLE) ? frame_len_of(cmd_tone) : flen_latched;

    mbx_order_seq u_seq (
        .frame_len (flen_sel),
        .idx       (idx_q),
        .first_idx (first_idx),
        .next_idx  (next_idx),
        .is_last   (is_last)
    );

    assign accept = (state_q == ST_WRITE) && wr_ready;

    mbx_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .expire (expire)
    );

    // Latch the request when a start is taken in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_q  <= 1'b0;
            on_q    <= 1'b0;
            len_q   <= '0;
            burst_q <= '0;
            msg_q   <= '0;
        end else if (state_q == ST_IDLE && start) begin
            tone_q  <= cmd_tone;
            on_q    <= tone_on;
            len_q   <= msg_len;
            burst_q <= burst_sel;
            msg_q   <= msg_bytes;
        end
    end

    // Main sequence: write, settle, advance, finish after the opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q   <= first_idx;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (wr_ready)
                        state_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (expire) begin
                        if (is_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q   <= next_idx;
                            state_q <= ST_WRITE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_en   = (state_q == ST_WRITE);
    assign wr_addr = {idx_q, 1'b0};
    assign wr_data = word;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
endmodule

// File: rtl/mbx_cmd_writer_chk.sv
// Checker for the mailbox writer port protocol, bound to the top module.
// Assumes SETTLE_CYCLES >= 1; the settle window uses a counter, not $past.
module mbx_cmd_writer_chk
    import mbx_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              wr_en,
    input logic              wr_ready,
    input logic              busy,
    input logic              done
);
    int unsigned       gap_q;
    logic              seen_q;
    logic [ADDR_W-1:0] last_addr_q;

    // Track cycles since the last accepted write and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= 0;
            seen_q      <= 1'b0;
            last_addr_q <= '1;
        end else if (wr_en && wr_ready) begin
            gap_q       <= 0;
            seen_q      <= 1'b1;
            last_addr_q <= wr_addr;
        end else begin
            if (gap_q != 32'hFFFF_FFFF)
                gap_q <= gap_q + 1;
            if (done)
                seen_q <= 1'b0;
        end
    end

    a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    a_r4_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready) |=> !wr_en);

    a_r4_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_q) |-> (gap_q >= SETTLE_CYCLES));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_en));

    a_r2_done_after_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen_q && last_addr_q == '0));
endmodule

bind mbx_cmd_writer mbx_cmd_writer_chk #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .wr_ready (wr_ready),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_mbx_cmd_writer.sv
`timescale 1ns/1ps
module sim_mbx_cmd_writer;
    localparam int S = 8;
    localparam logic [7:0] T_TYPE = 8'h02;
    localparam logic [7:0] T_SEND = 8'h08;
    localparam logic [7:0] T_ON   = 8'h03;
    localparam logic [7:0] T_OFF  = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_tone = 1'b0;
    logic        tone_on = 1'b0;
    logic [3:0]  msg_len = '0;
    logic [1:0]  burst_sel = '0;
    logic [79:0] msg_bytes = '0;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wr_en;
    logic        wr_ready;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mbx_cmd_writer #(.SETTLE_CYCLES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_tone(cmd_tone),
        .tone_on(tone_on), .msg_len(msg_len), .burst_sel(burst_sel),
        .msg_bytes(msg_bytes), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_en(wr_en), .wr_ready(wr_ready), .busy(busy), .done(done)
    );

    // Ready pattern: always ready, or ready one cycle in three.
    logic stall_mode = 1'b0;
    int   rcnt = 0;
    always @(posedge clk) rcnt <= rcnt + 1;
    assign wr_ready = stall_mode ? (rcnt % 3 == 2) : 1'b1;

    // Monitor at the falling edge: log writes, done pulses, hold breaks.
    logic [5:0]  lg_addr [0:63];
    logic [15:0] lg_data [0:63];
    int          lg_cyc  [0:63];
    int n_log = 0, n_done = 0, done_cyc = 0, cyc = 0, hold_err = 0;
    logic p_en = 0, p_rdy = 0;
    logic [5:0] p_addr = 0;
    logic [15:0] p_data = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (wr_en && wr_ready && n_log < 64) begin
                lg_addr[n_log] = wr_addr;
                lg_data[n_log] = wr_data;
                lg_cyc[n_log]  = cyc;
                n_log++;
            end
            if (done) begin
                n_done++;
                done_cyc = cyc;
            end
            if (p_en && !p_rdy && (!wr_en || wr_addr != p_addr || wr_data != p_data))
                hold_err++;
        end
        p_en = wr_en; p_rdy = wr_ready; p_addr = wr_addr; p_data = wr_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit tn, input bit on, input int len,
                                             input logic [1:0] b, input logic [79:0] m, input int idx);
        int lc;
        lc = (len > 10) ? 10 : len;
        if (tn) return (idx == 0) ? {T_TYPE, on ? T_ON : T_OFF} : 16'h0000;
        case (idx)
            0: return {T_TYPE, T_SEND};
            1: return 16'(lc + 2);
            2: return 16'(lc);
            3: return (b == 2'b10) ? 16'h0001 : (b == 2'b01) ? 16'h0000 : 16'hFFFF;
            default: return (idx - 4 < lc) ? {8'h00, m[8*(idx-4) +: 8]} : 16'h0000;
        endcase
    endfunction

    // Launch with the current inputs; optionally retrigger mid-run with changed inputs.
    task automatic launch(input bit retrigger);
        int t;
        n_log = 0; n_done = 0; hold_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", busy, 1);
        if (retrigger) begin
            repeat (3) @(negedge clk);
            cmd_tone = 1'b0; msg_len = 4'd5; burst_sel = 2'b10; tone_on = ~tone_on;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (n_done == 0 && t < 5000) begin
            @(negedge clk); t++;
        end
        chk(busy == 1'b0, "R5 busy low at done", busy, 0);
        repeat (S + 4) @(negedge clk);
    endtask

    // Compare the logged frame with the expected one.
    task automatic verify(input bit tn, input bit on, input int len, input logic [1:0] b,
                          input logic [79:0] m, input bit stalled);
        int flen, idx;
        string tag;
        flen = tn ? 2 : 18;
        chk(n_log == flen, tn ? "R9 word count" : "R8 word count", n_log, flen);
        for (int p = 0; p < n_log && p < flen; p++) begin
            idx = (p < flen - 2) ? p + 2 : (p == flen - 2) ? 1 : 0;
            chk(lg_addr[p] == 6'(2 * idx), "R2 address order", lg_addr[p], 2 * idx);
            if (tn) tag = "R9 tone word";
            else if (idx <= 2) tag = "R6 header word";
            else if (idx == 3) tag = "R7 burst word";
            else tag = "R8 message word";
            chk(lg_data[p] == exp_word(tn, on, len, b, m, idx), tag, lg_data[p],
                exp_word(tn, on, len, b, m, idx));
            if (p > 0) begin
                if (stalled) chk(lg_cyc[p] - lg_cyc[p-1] >= S + 1, "R4 settle gap",
                                 lg_cyc[p] - lg_cyc[p-1], S + 1);
                else chk(lg_cyc[p] - lg_cyc[p-1] == S + 1, "R4 settle gap",
                         lg_cyc[p] - lg_cyc[p-1], S + 1);
            end
        end
        chk(n_done == 1, "R5 done count", n_done, 1);
        if (n_log > 0)
            chk(done_cyc - lg_cyc[n_log-1] == S + 1, "R5 done timing",
                done_cyc - lg_cyc[n_log-1], S + 1);
        chk(hold_err == 0, "R3 hold while not ready", hold_err, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R1 wr_en reset", wr_en, 0);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0 && busy == 1'b0, "R1 idle after reset", {wr_en, busy}, 0);
    endtask

    task automatic t_tone(input bit on);
        cmd_tone = 1'b1; tone_on = on;
        launch(0);
        verify(1, on, 0, 2'b00, '0, 0);
    endtask

    task automatic t_msg(input int len, input logic [1:0] b, input logic [79:0] m, input bit stall);
        cmd_tone = 1'b0; msg_len = 4'(len); burst_sel = b; msg_bytes = m; stall_mode = stall;
        launch(0);
        verify(0, 0, len, b, m, stall);
        stall_mode = 1'b0;
    endtask

    // R10: second start with different inputs while busy must be ignored.
    task automatic t_busy_start();
        cmd_tone = 1'b1; tone_on = 1'b1;
        launch(1);
        verify(1, 1, 0, 2'b00, '0, 0);
        chk(n_done == 1, "R10 restart ignored", n_done, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tone(1);
        t_tone(0);
        t_msg(3, 2'b10, 80'h0000_0000_0000_0011_5AA5, 0);
        t_msg(10, 2'b00, 80'h9988_7766_5544_3322_1100, 0);
        t_msg(15, 2'b01, 80'hF1E2_D3C4_B5A6_9788_7961, 0);
        t_msg(0, 2'b11, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 0);
        t_msg(6, 2'b10, 80'h0000_0000_0605_0403_0201, 1);
        t_busy_start();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule